// File: doc/BRIEF.md
# Clock Device Configuration Target on a Two-Wire Bus

This block is the configuration port of a clock-generation device. It is a target on a two-wire serial bus (I2C signalling, SMBus-style command framing). It holds a bank of six eight-bit control registers and turns selected register bits into control outputs: four output enables, a spread-spectrum on/off control and a spread-depth select. A bus controller can read or write one register at a time, or move a run of registers in one transfer.

After the 7-bit address, the controller sends a command byte. The top bit of that byte picks single-register or block access. Two bits form a chip-select field. The low five bits give the register index, which is used for single-register access only.

- A block write sends a byte count followed by that many data bytes.
- A block read starts with a repeated START. The target then returns the count of registers it implements, followed by register contents from index 0 upward.

SCL and SDA are sampled by the block's own fast clock through synchronisers. The target drives SDA only by pulling it low: `sda_oe` high means the pad pulls low. Clock stretching is not used.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: The target acknowledges the address byte only when its upper seven bits equal 69h (D2h to write, D3h to read). Any other address gets no acknowledge, and every later bit is ignored until the next START or STOP.
- R2: After reset the six registers at indices 0 to 5 hold 7Ch, 00h, EAh, AFh, 01h and 00h.
- R3: A command with bit 7 = 1 and bits 6:5 = 00 selects single-register access at the index in bits 4:0. In a write, the next byte is stored at that index. The address, command and data bytes are all acknowledged, and SDA is only ever pulled low after a falling SCL edge.
- R4: A single-register read is: write address, command, repeated START, read address. The target then returns the register at the commanded index, MSB first.
- R5: A command of 00h selects block write. The next byte is a count N, and the following N data bytes go to registers 0, 1, 2 and upward. Every byte is acknowledged, including data bytes beyond N, which are discarded.
- R6: A block read (command 00h, repeated START, read address) first returns 06h. It then returns registers 0 to 5 in ascending order for as long as the controller acknowledges.
- R7: The target does not acknowledge a command byte, and writes nothing, in either of these cases: bits 6:5 are not 00, or bit 7 = 0 with bits 4:0 not 00000.
- R8: Writes to indices 6 to 31 are acknowledged and change nothing. Reads at those indices, including reads that continue past index 5, return 00h.
- R9: A STOP or START at any point ends the current byte, releases SDA and discards a partly received byte. A controller NACK after a read byte makes the target release SDA and stay silent until the next START or STOP.
- R10: The outputs follow the register bits directly:
  - `out_en[k]` = register 0 bit 3+k, for k = 0 to 3;
  - `spread_on` = register 2 bit 2;
  - `spread_deep` = register 2 bit 7 (1 = deeper spread).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and logic clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (acknowledge or read data 0) |
| out_en | output | 4 | Per-output enables; bit k enables output k+1 |
| spread_on | output | 1 | Spread-spectrum modulation enable |
| spread_deep | output | 1 | Spread depth select: 0 shallow, 1 deep |

## Verification
The most delicate cycle is the SCL falling edge that ends an acknowledge slot in front of a read byte. On that one edge the target must release its own acknowledge and also drive the MSB of the next byte. When that MSB is 0, SDA is never released between the two bit slots.

The bench provokes this cycle with the first byte after the read address and with every byte after a controller ACK. It reads values whose MSB is 0 (the count 06h, 7Ch, 00h) and values whose MSB is 1 (EAh, AFh). It judges the result by the bytes the modelled controller reassembles from the bus. A second collision is a STOP arriving in the middle of a data byte. The bench checks that the byte is discarded and that the next transfer is decoded cleanly.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
package clkcfg_pkg;

  localparam int NREG    = 6;
  localparam int IDX_W   = 5;
  localparam int DATA_W  = 8;
  localparam logic [6:0] DEV_ADDR = 7'h69;

  // bit positions of decoded controls
  localparam int EN_LSB    = 3;
  localparam int NUM_EN    = 4;
  localparam int SPRD_BIT  = 2;
  localparam int DEEP_BIT  = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WR,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_RNEXT,
    ST_SKIP
  } tgt_state_t;

  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    case (idx)
      0:       reg_default = 8'h7C;
      2:       reg_default = 8'hEA;
      3:       reg_default = 8'hAF;
      4:       reg_default = 8'h01;
      default: reg_default = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/clkcfg_line_sync.sv
`timescale 1ns/1ps
module clkcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/clkcfg_regbank.sv
`timescale 1ns/1ps
module clkcfg_regbank
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_EN-1:0] out_en,
  output logic              spread_on,
  output logic              spread_deep
);

  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [NREG-1:0][DATA_W-1:0] regs_nx;

  always_comb begin
    regs_nx = regs;
    for (int i = 0; i < NREG; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) regs_nx[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reg_default(i);
    end else if (wr_en) begin
      regs <= regs_nx;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = regs[i];
    end
  end

  for (genvar k = 0; k < NUM_EN; k++) begin : g_en
    assign out_en[k] = regs[0][EN_LSB+k];
  end
  assign spread_on   = regs[2][SPRD_BIT];
  assign spread_deep = regs[2][DEEP_BIT];

  // R8: an index outside the bank leaves every register untouched
  a_r8_oob_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= IDX_W'(NREG))) |=> $stable(regs));

endmodule

// File: rtl/clkcfg_proto_fsm.sv
`timescale 1ns/1ps
module clkcfg_proto_fsm
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              sda_oe
);

  tgt_state_t        state, n_state, after, n_after;
  logic [DATA_W-1:0] shreg, n_shreg;
  logic [3:0]        bitcnt, n_bitcnt;
  logic              n_oe;
  logic [IDX_W-1:0]  ptr, n_ptr, ptr_inc;
  logic [DATA_W-1:0] remain, n_remain;
  logic              cnt_pend, n_cnt_pend;
  logic              rcnt_pend, n_rcnt_pend;
  logic [DATA_W-1:0] tx_byte;
  logic              cmd_ok;

  assign ptr_inc = (ptr == '1) ? ptr : ptr + 1'b1;
  assign tx_byte = rcnt_pend ? DATA_W'(NREG) : rd_data;
  assign cmd_ok  = (shreg[6:5] == 2'b00) && (shreg[7] || (shreg[4:0] == 5'd0));
  assign rd_idx  = ptr;

  always_comb begin
    n_state     = state;
    n_after     = after;
    n_shreg     = shreg;
    n_bitcnt    = bitcnt;
    n_oe        = sda_oe;
    n_ptr       = ptr;
    n_remain    = remain;
    n_cnt_pend  = cnt_pend;
    n_rcnt_pend = rcnt_pend;
    wr_en       = 1'b0;
    wr_idx      = ptr;
    wr_data     = shreg;

    if (stop_c) begin
      n_state = ST_IDLE;
      n_oe    = 1'b0;
    end else if (start_c) begin
      n_state  = ST_ADDR;
      n_bitcnt = '0;
      n_oe     = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_CMD, ST_WR: begin
          if (scl_rise) begin
            n_shreg  = {shreg[DATA_W-2:0], sda_s};
            n_bitcnt = bitcnt + 1'b1;
          end else if (scl_fall && (bitcnt == 4'd8)) begin
            n_bitcnt = '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                n_oe    = 1'b1;
                n_state = ST_ACK;
                n_after = shreg[0] ? ST_TX : ST_CMD;
              end else begin
                n_state = ST_SKIP;
              end
            end else if (state == ST_CMD) begin
              if (cmd_ok) begin
                n_oe        = 1'b1;
                n_state     = ST_ACK;
                n_after     = ST_WR;
                n_ptr       = shreg[4:0];
                n_cnt_pend  = ~shreg[7];
                n_rcnt_pend = ~shreg[7];
                n_remain    = 8'd1;
              end else begin
                n_state = ST_SKIP;
              end
            end else begin
              n_oe    = 1'b1;
              n_state = ST_ACK;
              n_after = ST_WR;
              if (cnt_pend) begin
                n_remain   = shreg;
                n_cnt_pend = 1'b0;
              end else if (remain != '0) begin
                wr_en    = 1'b1;
                n_ptr    = ptr_inc;
                n_remain = remain - 1'b1;
              end
            end
          end
        end
        ST_ACK, ST_RNEXT: begin
          if (scl_fall) begin
            if ((state == ST_RNEXT) || (after == ST_TX)) begin
              n_shreg  = tx_byte;
              n_oe     = ~tx_byte[7];
              n_bitcnt = 4'd1;
              n_state  = ST_TX;
              if (rcnt_pend) n_rcnt_pend = 1'b0;
              else           n_ptr       = ptr_inc;
            end else begin
              n_oe    = 1'b0;
              n_state = after;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              n_oe    = 1'b0;
              n_state = ST_RACK;
            end else begin
              n_oe     = ~shreg[6];
              n_shreg  = {shreg[DATA_W-2:0], 1'b0};
              n_bitcnt = bitcnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) n_state = sda_s ? ST_SKIP : ST_RNEXT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after     <= ST_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      sda_oe    <= 1'b0;
      ptr       <= '0;
      remain    <= '0;
      cnt_pend  <= 1'b0;
      rcnt_pend <= 1'b0;
    end else begin
      state     <= n_state;
      after     <= n_after;
      shreg     <= n_shreg;
      bitcnt    <= n_bitcnt;
      sda_oe    <= n_oe;
      ptr       <= n_ptr;
      remain    <= n_remain;
      cnt_pend  <= n_cnt_pend;
      rcnt_pend <= n_rcnt_pend;
    end
  end

  // R3: SDA is only ever pulled low following a falling SCL edge
  a_r3_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R9: a STOP leaves the target idle with SDA released
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_oe && (state == ST_IDLE)));

  // R1: a target that is not addressed never pulls SDA
  a_r1_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_oe);

  // R6: a byte being sent always has a bit count between 1 and 8
  a_r6_tx_bitcount: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX) |-> ((bitcnt >= 4'd1) && (bitcnt <= 4'd8)));

endmodule

// File: rtl/clkcfg_i2c_target.sv
`timescale 1ns/1ps
module clkcfg_i2c_target
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NUM_EN-1:0] out_en,
  output logic              spread_on,
  output logic              spread_deep
);

  logic [1:0]        rst_sh;
  logic              rst_int_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_int_n = rst_sh[1];

  clkcfg_line_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  clkcfg_proto_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe)
  );

  clkcfg_regbank u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .out_en      (out_en),
    .spread_on   (spread_on),
    .spread_deep (spread_deep)
  );

  // R10: decoded outputs only move while a write is being committed
  a_r10_outputs_on_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(wr_en) |-> ($stable(out_en) && $stable(spread_on) && $stable(spread_deep)));

  logic unused_scl;
  assign unused_scl = scl_s;

endmodule

// File: tb/sim_clkcfg_i2c_target.sv
`timescale 1ns/1ps
module sim_clkcfg_i2c_target;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_oe;
  logic [3:0] out_en;
  logic       spread_on, spread_deep;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;
  logic [7:0] exp_r [6];

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  clkcfg_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .out_en(out_en), .spread_on(spread_on), .spread_deep(spread_deep)
  );

  task automatic hp();
    repeat (20) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic b_start();
    sda_m = 1; scl_m = 1; hp(); sda_m = 0; hp(); scl_m = 0; hp();
  endtask
  task automatic b_rstart();
    sda_m = 1; hp(); scl_m = 1; hp(); sda_m = 0; hp(); scl_m = 0; hp();
  endtask
  task automatic b_stop();
    sda_m = 0; hp(); scl_m = 1; hp(); sda_m = 1; hp();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1; hp(); scl_m = 0; hp();
    end
    sda_m = 1; hp(); scl_m = 1; hp(); ack = ~sda_bus; scl_m = 0; hp();
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1; hp(); b[i] = sda_bus; scl_m = 0;
    end
    hp(); sda_m = nack; hp(); scl_m = 1; hp(); scl_m = 0; hp(); sda_m = 1;
  endtask

  task automatic xfer_write(input logic [7:0] cmd, input logic [7:0] d, input string req);
    logic a;
    b_start();
    put_byte(8'hD2, a); chk(req, a, 1);
    put_byte(cmd, a);   chk(req, a, 1);
    put_byte(d, a);     chk(req, a, 1);
    b_stop();
  endtask

  task automatic xfer_read(input logic [7:0] cmd, output logic [7:0] v);
    logic a0, a1, a2;
    b_start();
    put_byte(8'hD2, a0);
    put_byte(cmd, a1);
    b_rstart();
    put_byte(8'hD3, a2);
    get_byte(1'b1, v);
    b_stop();
    chk("R4 acks", {5'd0, a0, a1, a2}, 8'h07);
  endtask

  task automatic t_reset();
    chk("R2 sda_oe idle", {7'd0, sda_oe}, 8'h00);
    chk("R10 out_en reset", {4'd0, out_en}, 8'h0F);
    chk("R10 spread_on reset", {7'd0, spread_on}, 8'h00);
    chk("R10 spread_deep reset", {7'd0, spread_deep}, 8'h01);
  endtask

  task automatic t_byte_read_defaults();
    logic [7:0] v;
    for (int i = 0; i < 6; i++) begin
      xfer_read(8'h80 | 8'(i), v);
      chk("R2 R4 default by byte read", v, exp_r[i]);
    end
  endtask

  task automatic t_byte_write();
    logic [7:0] v;
    xfer_write(8'h82, 8'h04, "R3 ack");
    exp_r[2] = 8'h04;
    chk("R10 spread_on after write", {7'd0, spread_on}, 8'h01);
    chk("R10 spread_deep after write", {7'd0, spread_deep}, 8'h00);
    xfer_write(8'h80, 8'h28, "R3 ack");
    exp_r[0] = 8'h28;
    chk("R10 out_en after write", {4'd0, out_en}, 8'h05);
    xfer_read(8'h82, v);
    chk("R3 readback", v, 8'h04);
  endtask

  task automatic t_addr_mismatch();
    logic a;
    b_start();
    put_byte(8'hA0, a); chk("R1 wrong address nack", {7'd0, a}, 8'h00);
    put_byte(8'h81, a); chk("R1 ignored after mismatch", {7'd0, a}, 8'h00);
    put_byte(8'h55, a); chk("R1 ignored data", {7'd0, a}, 8'h00);
    b_stop();
    chk("R1 no write", {4'd0, out_en}, {4'd0, exp_r[0][6:3]});
  endtask

  task automatic t_bad_cmd();
    logic a;
    logic [7:0] v;
    b_start();
    put_byte(8'hD2, a);
    put_byte(8'hA1, a); chk("R7 chip-select nack", {7'd0, a}, 8'h00);
    put_byte(8'h77, a); chk("R7 data after bad cmd nack", {7'd0, a}, 8'h00);
    b_stop();
    b_start();
    put_byte(8'hD2, a);
    put_byte(8'h03, a); chk("R7 block offset nack", {7'd0, a}, 8'h00);
    b_stop();
    xfer_read(8'h81, v);
    chk("R7 register unchanged", v, exp_r[1]);
  endtask

  task automatic t_block_write();
    logic a;
    logic [7:0] v;
    logic [7:0] d [4];
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
    b_start();
    put_byte(8'hD2, a); chk("R5 addr ack", {7'd0, a}, 8'h01);
    put_byte(8'h00, a); chk("R5 cmd ack", {7'd0, a}, 8'h01);
    put_byte(8'h03, a); chk("R5 count ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < 4; i++) begin
      put_byte(d[i], a); chk("R5 data ack", {7'd0, a}, 8'h01);
    end
    b_stop();
    for (int i = 0; i < 3; i++) exp_r[i] = d[i];
    chk("R10 out_en after block", {4'd0, out_en}, 8'h02);
    for (int i = 0; i < 4; i++) begin
      xfer_read(8'h80 | 8'(i), v);
      chk("R5 block write result", v, exp_r[i]);
    end
  endtask

  task automatic t_block_read();
    logic a;
    logic [7:0] v;
    exp_r[0] = 8'h7C; exp_r[2] = 8'hEA;
    xfer_write(8'h80, 8'h7C, "R3 ack");
    xfer_write(8'h82, 8'hEA, "R3 ack");
    b_start();
    put_byte(8'hD2, a);
    put_byte(8'h00, a);
    b_rstart();
    put_byte(8'hD3, a); chk("R6 read addr ack", {7'd0, a}, 8'h01);
    get_byte(1'b0, v);  chk("R6 count byte", v, 8'h06);
    for (int i = 0; i < 6; i++) begin
      get_byte(1'b0, v); chk("R6 block data", v, exp_r[i]);
    end
    get_byte(1'b0, v); chk("R8 past end", v, 8'h00);
    get_byte(1'b1, v); chk("R8 past end last", v, 8'h00);
    chk("R9 released after nack", {7'd0, sda_oe}, 8'h00);
    b_stop();
  endtask

  task automatic t_out_of_range();
    logic [7:0] v;
    xfer_write(8'h87, 8'h55, "R8 ack");
    xfer_read(8'h87, v);
    chk("R8 read beyond bank", v, 8'h00);
    xfer_read(8'h85, v);
    chk("R8 bank intact", v, exp_r[5]);
  endtask

  task automatic t_abort();
    logic a;
    logic [7:0] v;
    b_start();
    put_byte(8'hD2, a);
    put_byte(8'h81, a);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'(i % 2); hp(); scl_m = 1; hp(); scl_m = 0; hp();
    end
    b_stop();
    chk("R9 released after stop", {7'd0, sda_oe}, 8'h00);
    xfer_read(8'h81, v);
    chk("R9 partial byte discarded", v, exp_r[1]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    exp_r[0] = 8'h7C; exp_r[1] = 8'h00; exp_r[2] = 8'hEA;
    exp_r[3] = 8'hAF; exp_r[4] = 8'h01; exp_r[5] = 8'h00;
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (10) @(negedge clk);
    t_reset();
    t_byte_read_defaults();
    t_byte_write();
    t_addr_mismatch();
    t_bad_cmd();
    t_block_write();
    t_block_read();
    t_out_of_range();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule